// File: doc/BRIEF.md
# Cascadable Eight-Input Priority Interrupt Controller

The block collects eight interrupt requests and chooses which one goes to the processor next. Each input is either edge-sensitive or level-sensitive. Inputs are ranked in fully nested order, with input 0 highest. Requests can be masked. When the processor acknowledges, the block hands back an interrupt vector. The vector combines a programmed base with the number of the winning input.

Software uses two register addresses. Writes to the command address start initialization, end interrupts and choose what that address reads back. Writes to the data address carry the remaining setup words and, once setup is complete, the mask.

A pin selects whether the unit is a master or a slave, so several units can be cascaded. A master that grants an input with a slave behind it publishes the input number on the cascade lines. A slave answers an acknowledge only when the cascade lines carry its own identifier.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the pending and in-service sets are empty, the mask is 0xFF, `int_out` is low, and a command-address read returns the pending set.
- R2: A command write with bit 4 set restarts setup. The next data writes are then taken in order: the vector base, the cascade word, and a mode word only if bit 0 of the restart byte was 1. Only after that does a data write load the mask. The mask reads back at the data address.
- R3: A set mask bit keeps its input from raising `int_out`, but the request is still recorded as pending. The setup-restart write sets the mask to 0xFF.
- R4: In edge mode a rising input sets its pending bit. The bit stays set after the input falls and is cleared only when that input is granted.
- R5: An input is level-sensitive when its `level_sel` bit is 1, or for all inputs when bit 3 of the restart byte was 1. A level-sensitive pending bit follows the input while that input is not in service.
- R6: `int_out` is high only when an unmasked pending input has a higher priority (lower number) than every in-service input.
- R7: An `ack` pulse while `int_out` is high moves the highest unmasked pending input n into service and clears its pending bit. In the cycle after the pulse, `vec_valid` is 1 and `vec_out` = {base[7:3], n}.
- R8: A command write of 0x20 (bit 4 clear, bit 3 clear) clears the highest-priority in-service bit and leaves the other in-service bits unchanged.
- R9: A command write with bit 4 clear and bit 3 set selects the command-address readback. Low bits 11 select the in-service set and low bits 10 select the pending set. Every setup restart returns the readback to the pending set.
- R10: A master (`slave_mode`=0) that grants input n whose bit is set in the cascade word drives `cas_out`=n and `cas_en`=1 for one cycle, with `vec_valid`=0.
- R11: A slave (`slave_mode`=1) grants on `ack` only when `cas_in` equals cascade word bits [2:0]. When they differ, the pending and in-service sets are left unchanged and `vec_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_sel | input | 1 | 0 selects the command address, 1 selects the data address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Readback for the selected address |
| irq_in | input | 8 | Request inputs |
| level_sel | input | 8 | Per-input level-sensitive select |
| slave_mode | input | 1 | 1 makes the unit a cascade slave |
| ack | input | 1 | One-cycle interrupt acknowledge |
| cas_in | input | 3 | Cascade identifier seen by a slave |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Granted vector |
| vec_valid | output | 1 | `vec_out` is valid this cycle |
| cas_out | output | 3 | Cascade identifier from a master |
| cas_en | output | 1 | `cas_out` is valid this cycle |

## Verification
The hardest state to reach is nested service, where a lower-priority request sits pending behind an in-service input while a higher-priority one preempts it. The bench builds this in stages. It grants a mid-priority input, raises a lower input that must stay silent, then raises a higher input and grants it too. It then issues two end-of-interrupt writes and reads the in-service set after each one, checking that bits are released highest first and that the waiting request comes forward only at the end.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       port_sel,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic [7:0] irq_in,
  input  logic [7:0] level_sel,
  input  logic       slave_mode,
  input  logic       ack,
  input  logic [2:0] cas_in,
  output logic       int_out,
  output logic [7:0] vec_out,
  output logic       vec_valid,
  output logic [2:0] cas_out,
  output logic       cas_en
);
  typedef enum logic [1:0] {S_RUN, S_BASE, S_CASC, S_MODE} setup_t;

  setup_t     st;
  logic [7:0] irr, isr, imr, irq_q, base, casc;
  logic       want_mode, lvl_all, show_isr;

  function automatic logic [2:0] top_bit(input logic [7:0] v);
    top_bit = 3'd0;
    for (int i = 7; i >= 0; i--)
      if (v[i]) top_bit = i[2:0];
  endfunction

  wire        cmd_wr  = wr_en && !port_sel;
  wire        dat_wr  = wr_en && port_sel;
  wire        restart = cmd_wr && wr_data[4];
  wire        eoi     = cmd_wr && !wr_data[4] && !wr_data[3] && wr_data == 8'h20;
  wire        rdsel   = cmd_wr && !wr_data[4] && wr_data[3] && wr_data[1];
  wire [7:0]  elig    = irr & ~imr;
  wire [2:0]  req_n   = top_bit(elig);
  wire [2:0]  srv_n   = top_bit(isr);
  wire [7:0]  lvl     = level_sel | {8{lvl_all}};

  assign int_out = (elig != 8'h00) && (isr == 8'h00 || req_n < srv_n);
  wire   grant   = ack && int_out && (!slave_mode || cas_in == casc[2:0]);
  wire [7:0] gbit = grant ? (8'h01 << req_n) : 8'h00;
  wire [7:0] ebit = (eoi && isr != 8'h00) ? (8'h01 << srv_n) : 8'h00;

  assign rd_data = port_sel ? imr : (show_isr ? isr : irr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_RUN; irr <= '0; isr <= '0; imr <= 8'hFF; irq_q <= '0;
      base <= '0; casc <= '0; want_mode <= 1'b0; lvl_all <= 1'b0; show_isr <= 1'b0;
      vec_out <= '0; vec_valid <= 1'b0; cas_out <= '0; cas_en <= 1'b0;
    end else begin
      irq_q     <= irq_in;
      vec_valid <= 1'b0;
      cas_en    <= 1'b0;
      if (restart) begin
        st <= S_BASE; want_mode <= wr_data[0]; lvl_all <= wr_data[3];
        imr <= 8'hFF; irr <= '0; isr <= '0; show_isr <= 1'b0;
      end else begin
        for (int i = 0; i < 8; i++)
          irr[i] <= lvl[i] ? (irq_in[i] & ~isr[i]) : ((irr[i] | (irq_in[i] & ~irq_q[i])) & ~gbit[i]);
        isr <= (isr & ~ebit) | gbit;
        if (rdsel) show_isr <= wr_data[0];
        if (dat_wr) begin
          case (st)
            S_BASE: begin base <= wr_data; st <= S_CASC; end
            S_CASC: begin casc <= wr_data; st <= want_mode ? S_MODE : S_RUN; end
            S_MODE: st <= S_RUN;
            default: imr <= wr_data;
          endcase
        end
        if (grant) begin
          vec_out <= {base[7:3], req_n};
          if (!slave_mode && casc[req_n]) begin
            cas_out <= req_n; cas_en <= 1'b1;
          end else begin
            vec_valid <= 1'b1;
          end
        end
      end
    end
  end
endmodule

module prio_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       port_sel,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       ack,
  input logic       slave_mode,
  input logic       int_out,
  input logic       vec_valid,
  input logic       cas_en,
  input logic [7:0] vec_out,
  input logic [7:0] irr,
  input logic [7:0] isr,
  input logic [7:0] imr,
  input logic [7:0] base
);
  AST_RESTART_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !port_sel && wr_data[4]) |=> imr == 8'hFF); // R3
  AST_INT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (irr & ~imr) != 8'h00); // R6
  AST_ACK_ADDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_out && !slave_mode && !wr_en) |=> $countones(isr) == $countones($past(isr)) + 1); // R7
  AST_VEC_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> vec_out[7:3] == base[7:3]); // R7
  AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !port_sel && wr_data == 8'h20 && isr != 8'h00 && !ack) |=> $countones(isr) + 1 == $countones($past(isr))); // R8
  AST_OUT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_valid && cas_en)); // R10
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .wr_en(wr_en), .wr_data(wr_data),
  .ack(ack), .slave_mode(slave_mode), .int_out(int_out), .vec_valid(vec_valid),
  .cas_en(cas_en), .vec_out(vec_out), .irr(irr), .isr(isr), .imr(imr), .base(base)
);

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       port_sel = 1'b0, wr_en = 1'b0, slave_mode = 1'b0, ack = 1'b0;
  logic [7:0] wr_data = '0, irq_in = '0, level_sel = '0;
  logic [2:0] cas_in = '0;
  logic [7:0] rd_data, vec_out;
  logic       int_out, vec_valid, cas_en;
  logic [2:0] cas_out;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  prio_irq_ctrl dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(posedge clk); #2; endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    port_sel = sel; wr_data = d; wr_en = 1'b1; cyc(); wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    port_sel = sel; #1; d = rd_data;
  endtask

  task automatic pulse_ack(input logic [2:0] id);
    cas_in = id; ack = 1'b1; cyc(); ack = 1'b0;
  endtask

  task automatic setup(input logic [7:0] w1, input logic [7:0] vb, input logic [7:0] cw);
    wr(1'b0, w1); wr(1'b1, vb); wr(1'b1, cw);
    if (w1[0]) wr(1'b1, 8'h01);
    wr(1'b1, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(1'b1, d); chk("R1 mask", d, 8'hFF);
    rd(1'b0, d); chk("R1 irr", d, 8'h00);
    chk("R1 int", int_out, 0);
  endtask

  task automatic t_setup_seq();
    logic [7:0] d;
    wr(1'b0, 8'h10); wr(1'b1, 8'h40); wr(1'b1, 8'h00); wr(1'b1, 8'h5A);
    rd(1'b1, d); chk("R2 mask after two words", d, 8'h5A);
    wr(1'b0, 8'h11); rd(1'b1, d); chk("R3 restart mask", d, 8'hFF);
    wr(1'b1, 8'h40); wr(1'b1, 8'h00); wr(1'b1, 8'h01);
    rd(1'b1, d); chk("R2 mode word not mask", d, 8'hFF);
    wr(1'b1, 8'h3C); rd(1'b1, d); chk("R2 mask after three words", d, 8'h3C);
  endtask

  task automatic t_edge_mask();
    logic [7:0] d;
    setup(8'h11, 8'h40, 8'h00); wr(1'b1, 8'hFF);
    irq_in[3] = 1'b1; cyc();
    rd(1'b0, d); chk("R3 masked pending", d, 8'h08);
    chk("R3 masked no int", int_out, 0);
    wr(1'b1, 8'h00); chk("R6 int after unmask", int_out, 1);
    irq_in[3] = 1'b0; cyc();
    rd(1'b0, d); chk("R4 held after fall", d, 8'h08);
    pulse_ack(3'd0);
    chk("R7 vec_valid", vec_valid, 1); chk("R7 vector", vec_out, 8'h43);
    rd(1'b0, d); chk("R4 cleared by grant", d, 8'h00);
    wr(1'b0, 8'h0B); rd(1'b0, d); chk("R9 isr readback", d, 8'h08);
    wr(1'b0, 8'h0A); rd(1'b0, d); chk("R9 irr readback", d, 8'h00);
    wr(1'b0, 8'h0B); wr(1'b0, 8'h11);
    rd(1'b0, d); chk("R9 default after setup", d, 8'h00);
  endtask

  task automatic t_nested();
    logic [7:0] d;
    setup(8'h11, 8'h40, 8'h00); wr(1'b0, 8'h0B);
    irq_in = 8'h08; cyc(); pulse_ack(3'd0);
    irq_in = 8'h28; cyc(); chk("R6 lower blocked", int_out, 0);
    irq_in = 8'h2A; cyc(); chk("R6 higher preempts", int_out, 1);
    pulse_ack(3'd0); chk("R7 vector 1", vec_out, 8'h41);
    rd(1'b0, d); chk("R7 nested isr", d, 8'h0A);
    wr(1'b0, 8'h20); rd(1'b0, d); chk("R8 first eoi", d, 8'h08);
    chk("R6 still blocked", int_out, 0);
    wr(1'b0, 8'h20); rd(1'b0, d); chk("R8 second eoi", d, 8'h00);
    chk("R6 waiting comes forward", int_out, 1);
    irq_in = 8'h00;
  endtask

  task automatic t_level();
    logic [7:0] d;
    setup(8'h19, 8'h40, 8'h00);
    irq_in[2] = 1'b1; cyc(); rd(1'b0, d); chk("R5 level high", d, 8'h04);
    irq_in[2] = 1'b0; cyc(); rd(1'b0, d); chk("R5 level low", d, 8'h00);
    setup(8'h11, 8'h40, 8'h00); level_sel = 8'h80;
    irq_in[7] = 1'b1; cyc(); rd(1'b0, d); chk("R5 pin level high", d, 8'h80);
    irq_in[7] = 1'b0; cyc(); rd(1'b0, d); chk("R5 pin level low", d, 8'h00);
    level_sel = 8'h00;
  endtask

  task automatic t_master();
    setup(8'h11, 8'h40, 8'h04);
    irq_in[2] = 1'b1; cyc(); pulse_ack(3'd0);
    chk("R10 cas_en", cas_en, 1); chk("R10 cas_out", cas_out, 2);
    chk("R10 no vector", vec_valid, 0);
    irq_in = 8'h00;
  endtask

  task automatic t_slave();
    logic [7:0] d;
    slave_mode = 1'b1; setup(8'h11, 8'h48, 8'h02);
    irq_in[0] = 1'b1; cyc(); pulse_ack(3'd3);
    chk("R11 mismatch no vector", vec_valid, 0);
    rd(1'b0, d); chk("R11 mismatch keeps pending", d, 8'h01);
    wr(1'b0, 8'h0B); rd(1'b0, d); chk("R11 mismatch isr empty", d, 8'h00);
    pulse_ack(3'd2);
    chk("R11 match vector valid", vec_valid, 1); chk("R11 match vector", vec_out, 8'h48);
    irq_in = 8'h00; slave_mode = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1; cyc();
    t_reset(); t_setup_seq(); t_edge_mask(); t_nested(); t_level(); t_master(); t_slave();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule